// File: doc/BRIEF.md
# Shadow Stack Page Permission Checker

This block sits behind first-stage address translation and gives the verdict on one memory access per cycle as far as shadow stacks are concerned. It takes the R, W and X bits of the leaf page table entry and the kind of access, which is a regular load, a regular store, a shadow stack load or a shadow stack store. One clock later it reports one of three verdicts: allowed, store/AMO access fault or store/AMO page fault. It also reports the matching exception cause code and a flag that marks the page as a shadow stack page.

When the feature enable is high, the leaf encoding R=0, W=1, X=0 names a shadow stack page. Only shadow stack accesses may store to such a page. Regular loads from it stay legal, so unwinders and debuggers can read the true return chain. Shadow stack accesses that reach a read-only page raise a page fault, which lets copy-on-write run. Shadow stack accesses that reach an ordinary writable page, or a page that cannot be read, raise an access fault. When the enable is low, the same encoding keeps its old reserved meaning and every access to it raises a page fault.

Ordinary R/W/X permission checking of regular accesses on non-shadow pages is done by other logic. This block lets those accesses through.

Top module: `ssp_perm_check`

## Requirements
- R1: While reset is asserted (rst_n low) and in the cycle after it is released, rsp_valid is 0, verdict is 2'b00 (allowed), cause is 0 and rsp_ss_page is 0.
- R2: rsp_ss_page is 1 exactly when the request had ss_enable=1 and {pte_r,pte_w,pte_x}=3'b010; otherwise it is 0.
- R3: A regular load (acc_kind 2'b00) to a shadow stack page (ss_enable=1, RWX=010) gives verdict 2'b00 (allowed).
- R4: A regular store (acc_kind 2'b01) to a shadow stack page gives verdict 2'b01 (store/AMO access fault).
- R5: A shadow stack access (acc_kind 2'b10 load or 2'b11 store) to a shadow stack page gives verdict 2'b00 (allowed).
- R6: A shadow stack access (acc_kind 2'b1x) to a read-only page (R=1, W=0, any X) gives verdict 2'b10 (store/AMO page fault).
- R7: A shadow stack access (acc_kind 2'b1x) to a read-write page (R=1, W=1, any X) gives verdict 2'b01 (store/AMO access fault).
- R8: A shadow stack access (acc_kind 2'b1x) to a non-readable page other than the shadow stack encoding (RWX 000, 001 or 011) gives verdict 2'b01 (store/AMO access fault).
- R9: With ss_enable=0, RWX=010 gives verdict 2'b10 (store/AMO page fault) for all four access kinds.
- R10: A regular access (acc_kind 2'b00 or 2'b01) to any encoding other than RWX=010 gives verdict 2'b00 (allowed).
- R11: cause is 7 for verdict 2'b01, 15 for verdict 2'b10 and 0 for verdict 2'b00.
- R12: Results appear one clock after the request. rsp_valid equals req_valid delayed by one clock. In a cycle after req_valid was low, verdict, cause and rsp_ss_page keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ss_enable | input | 1 | Enables the shadow stack page interpretation |
| req_valid | input | 1 | Request present this cycle |
| pte_r | input | 1 | Leaf entry readable bit |
| pte_w | input | 1 | Leaf entry writable bit |
| pte_x | input | 1 | Leaf entry executable bit |
| acc_kind | input | 2 | 00 load, 01 store, 10 shadow stack load, 11 shadow stack store |
| rsp_valid | output | 1 | Verdict for last cycle's request is present |
| verdict | output | 2 | 00 allowed, 01 store/AMO access fault, 10 store/AMO page fault |
| cause | output | CAUSE_W | Exception cause code for the verdict |
| rsp_ss_page | output | 1 | The page was classified as a shadow stack page |

## Verification
The hardest case to reach is the same RWX=010 encoding giving three different results. With the enable high it is either allowed or an access fault, depending on the access kind. With the enable low it is a page fault for every kind. A check on one side only would miss an inverted enable. The bench therefore sweeps every combination of enable, all eight RWX encodings and all four access kinds back to back. It inserts idle cycles between groups, which shows that the held outputs do not move when no request is present.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD     = 2'b00,
        ACC_STORE    = 2'b01,
        ACC_SS_LOAD  = 2'b10,
        ACC_SS_STORE = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        VD_ALLOW        = 2'b00,
        VD_ACCESS_FAULT = 2'b01,
        VD_PAGE_FAULT   = 2'b10
    } verdict_e;

    typedef enum logic [2:0] {
        PC_SHADOW     = 3'd0,
        PC_RESERVED   = 3'd1,
        PC_READ_ONLY  = 3'd2,
        PC_READ_WRITE = 3'd3,
        PC_NO_READ    = 3'd4
    } page_class_e;

    localparam int unsigned CAUSE_STORE_ACCESS = 7;
    localparam int unsigned CAUSE_STORE_PAGE   = 15;

endpackage

// File: rtl/ssp_pte_class.sv
module ssp_pte_class
    import ssp_pkg::*;
(
    input  logic        feat_en,
    input  logic        r,
    input  logic        w,
    input  logic        x,
    output page_class_e pclass,
    output logic        is_shadow
);
    always_comb begin
        unique case ({r, w, x})
            3'b010:         pclass = feat_en ? PC_SHADOW : PC_RESERVED;
            3'b100, 3'b101: pclass = PC_READ_ONLY;
            3'b110, 3'b111: pclass = PC_READ_WRITE;
            default:        pclass = PC_NO_READ;
        endcase
    end

    assign is_shadow = (pclass == PC_SHADOW);
endmodule

// File: rtl/ssp_fault_rule.sv
module ssp_fault_rule
    import ssp_pkg::*;
(
    input  page_class_e pclass,
    input  logic [1:0]  kind,
    output verdict_e    vd
);
    logic is_ss_acc;
    assign is_ss_acc = kind[1];

    always_comb begin
        vd = VD_ALLOW;
        unique case (pclass)
            PC_SHADOW: begin
                if (!is_ss_acc && kind[0]) vd = VD_ACCESS_FAULT;
                else                       vd = VD_ALLOW;
            end
            PC_RESERVED:   vd = VD_PAGE_FAULT;
            PC_READ_ONLY:  vd = is_ss_acc ? VD_PAGE_FAULT : VD_ALLOW;
            PC_READ_WRITE: vd = is_ss_acc ? VD_ACCESS_FAULT : VD_ALLOW;
            PC_NO_READ:    vd = is_ss_acc ? VD_ACCESS_FAULT : VD_ALLOW;
            default:       vd = VD_ALLOW;
        endcase
    end
endmodule

// File: rtl/ssp_cause_map.sv
module ssp_cause_map
    import ssp_pkg::*;
#(
    parameter int unsigned CAUSE_W = 5
) (
    input  verdict_e             vd,
    output logic [CAUSE_W-1:0]   code
);
    localparam logic [CAUSE_W-1:0] CODE_ACC  = CAUSE_W'(CAUSE_STORE_ACCESS);
    localparam logic [CAUSE_W-1:0] CODE_PAGE = CAUSE_W'(CAUSE_STORE_PAGE);

    always_comb begin
        unique case (vd)
            VD_ACCESS_FAULT: code = CODE_ACC;
            VD_PAGE_FAULT:   code = CODE_PAGE;
            default:         code = '0;
        endcase
    end
endmodule

// File: rtl/ssp_perm_check.sv
module ssp_perm_check
    import ssp_pkg::*;
#(
    parameter int unsigned CAUSE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ss_enable,
    input  logic               req_valid,
    input  logic               pte_r,
    input  logic               pte_w,
    input  logic               pte_x,
    input  logic [1:0]         acc_kind,
    output logic               rsp_valid,
    output logic [1:0]         verdict,
    output logic [CAUSE_W-1:0] cause,
    output logic               rsp_ss_page
);
    page_class_e        pclass_c;
    logic               shadow_c;
    verdict_e           vd_c;
    logic [CAUSE_W-1:0] code_c;

    ssp_pte_class u_class (
        .feat_en   (ss_enable),
        .r         (pte_r),
        .w         (pte_w),
        .x         (pte_x),
        .pclass    (pclass_c),
        .is_shadow (shadow_c)
    );

    ssp_fault_rule u_rule (
        .pclass (pclass_c),
        .kind   (acc_kind),
        .vd     (vd_c)
    );

    ssp_cause_map #(.CAUSE_W(CAUSE_W)) u_cause (
        .vd   (vd_c),
        .code (code_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            verdict     <= VD_ALLOW;
            cause       <= '0;
            rsp_ss_page <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                verdict     <= vd_c;
                cause       <= code_c;
                rsp_ss_page <= shadow_c;
            end
        end
    end
endmodule

// File: rtl/ssp_perm_check_sva.sv
module ssp_perm_check_sva #(
    parameter int unsigned CAUSE_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ss_enable,
    input logic               req_valid,
    input logic               pte_r,
    input logic               pte_w,
    input logic               pte_x,
    input logic [1:0]         acc_kind,
    input logic               rsp_valid,
    input logic [1:0]         verdict,
    input logic [CAUSE_W-1:0] cause,
    input logic               rsp_ss_page
);
    p_regload_ss_allow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ss_enable && {pte_r, pte_w, pte_x} == 3'b010 && acc_kind == 2'b00)
        |=> verdict == 2'b00);

    p_regstore_ss_af_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ss_enable && {pte_r, pte_w, pte_x} == 3'b010 && acc_kind == 2'b01)
        |=> verdict == 2'b01);

    p_ss_ro_pf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pte_r && !pte_w && acc_kind[1]) |=> verdict == 2'b10);

    p_ss_rw_af_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pte_r && pte_w && acc_kind[1]) |=> verdict == 2'b01);

    p_disabled_pf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ss_enable && {pte_r, pte_w, pte_x} == 3'b010)
        |=> (verdict == 2'b10 && !rsp_ss_page));

    p_cause_af_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict == 2'b01) |-> cause == CAUSE_W'(7));

    p_cause_pf_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict == 2'b10) |-> cause == CAUSE_W'(15));

    p_valid_delay_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_hold_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(verdict) && $stable(cause) && $stable(rsp_ss_page)));
endmodule

bind ssp_perm_check ssp_perm_check_sva #(.CAUSE_W(CAUSE_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .ss_enable   (ss_enable),
    .req_valid   (req_valid),
    .pte_r       (pte_r),
    .pte_w       (pte_w),
    .pte_x       (pte_x),
    .acc_kind    (acc_kind),
    .rsp_valid   (rsp_valid),
    .verdict     (verdict),
    .cause       (cause),
    .rsp_ss_page (rsp_ss_page)
);

// File: tb/sim_ssp_perm_check.sv
`timescale 1ns/1ps
module sim_ssp_perm_check;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ss_enable;
    logic          req_valid;
    logic          pte_r, pte_w, pte_x;
    logic [1:0]    acc_kind;
    logic          rsp_valid;
    logic [1:0]    verdict;
    logic [CW-1:0] cause;
    logic          rsp_ss_page;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ssp_perm_check #(.CAUSE_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .ss_enable(ss_enable), .req_valid(req_valid),
        .pte_r(pte_r), .pte_w(pte_w), .pte_x(pte_x), .acc_kind(acc_kind),
        .rsp_valid(rsp_valid), .verdict(verdict), .cause(cause), .rsp_ss_page(rsp_ss_page)
    );

    int    exp_vd;
    int    exp_cause;
    int    exp_ss;
    string exp_tag;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model(input int en, input int rwx, input int kind);
        bit ss_acc;
        ss_acc = (kind >= 2);
        exp_ss = 0;
        if (rwx == 2 && en == 1) begin
            exp_ss = 1;
            if (ss_acc)         begin exp_vd = 0; exp_tag = "R5"; end
            else if (kind == 0) begin exp_vd = 0; exp_tag = "R3"; end
            else                begin exp_vd = 1; exp_tag = "R4"; end
        end else if (rwx == 2) begin
            exp_vd = 2; exp_tag = "R9";
        end else if (!ss_acc) begin
            exp_vd = 0; exp_tag = "R10";
        end else if (rwx == 4 || rwx == 5) begin
            exp_vd = 2; exp_tag = "R6";
        end else if (rwx == 6 || rwx == 7) begin
            exp_vd = 1; exp_tag = "R7";
        end else begin
            exp_vd = 1; exp_tag = "R8";
        end
        exp_cause = (exp_vd == 1) ? 7 : (exp_vd == 2) ? 15 : 0;
    endtask

    task automatic compare_all(input int vexp);
        chk(rsp_valid == 1'(vexp), "R12 rsp_valid", int'(rsp_valid), vexp);
        chk(int'(verdict) == exp_vd, exp_tag, int'(verdict), exp_vd);
        chk(int'(cause) == exp_cause, "R11 cause", int'(cause), exp_cause);
        chk(int'(rsp_ss_page) == exp_ss, "R2 ss_page", int'(rsp_ss_page), exp_ss);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        rst_n = 1'b0; ss_enable = 1'b0; req_valid = 1'b0;
        pte_r = 1'b0; pte_w = 1'b0; pte_x = 1'b0; acc_kind = 2'b00;
        repeat (3) @(negedge clk);
        exp_vd = 0; exp_cause = 0; exp_ss = 0; exp_tag = "R1 verdict";
        chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
        chk(verdict == 2'b00, "R1 verdict", int'(verdict), 0);
        chk(cause == '0, "R1 cause", int'(cause), 0);
        chk(rsp_ss_page == 1'b0, "R1 ss_page", int'(rsp_ss_page), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 rsp_valid after release", int'(rsp_valid), 0);
        chk(verdict == 2'b00, "R1 verdict after release", int'(verdict), 0);

        for (int en = 1; en >= 0; en--) begin
            for (int rwx = 0; rwx < 8; rwx++) begin
                for (int k = 0; k < 4; k++) begin
                    ss_enable = 1'(en);
                    {pte_r, pte_w, pte_x} = 3'(rwx);
                    acc_kind  = 2'(k);
                    req_valid = 1'b1;
                    model(en, rwx, k);
                    @(negedge clk);
                    compare_all(1);
                end
                // idle cycle with scrambled inputs: outputs must hold (R12)
                req_valid = 1'b0;
                ss_enable = ~ss_enable;
                {pte_r, pte_w, pte_x} = 3'(7 - rwx);
                acc_kind = 2'b01;
                @(negedge clk);
                compare_all(0);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule